// File: doc/BRIEF.md
# Interrupt Source to Level Mapper

This block gathers eight level-sensitive interrupt request lines and turns them into a sixteen-bit vector of processor priority levels. Each request line belongs to one level, set by a fixed sparse table. Two request lines have no level at all, and the block ignores them. A request that is present sets its pending bit. Every level that belongs to a pending request is then driven high. Several levels may be active together, and the processor picks the highest one itself.

A single one-byte control register sits behind a byte read/write port with no address. A write stores the byte with bit 6 forced low. Bit 0 acts as a global enable: while it is clear, all level outputs are held low, but the pending state keeps following the inputs. The level vector is registered. Each bit that changes produces a one-cycle raise or lower strobe, in the same cycle that the level output changes.

Top module: `irq_level_mapper`

## Requirements
- R1: While rst_ni is low, the control register reads 0x01, all pending state is cleared, and level_o, raise_o and lower_o are all zero.
- R2: reg_rdata_o always shows the stored control byte. A write with reg_we_i high stores reg_wdata_i with bit 6 cleared (mask 0xBF), and the new value is visible after the next rising edge.
- R3: Source bits 0 to 7 map to levels 0, 1, 4, 6, 8, 10, 0 and 14, in that order. A pending mapped source drives level_o at its level, so level_o bit k is source-driven only for k in {1, 4, 6, 8, 10, 14}.
- R4: Source bits 0 and 6 have level 0. They never set any pending state and never assert any bit of level_o, raise_o or lower_o.
- R5: Pending follows the input level and is not latched. Once a mapped source input goes low, its level deasserts, and a one-cycle pulse gives a one-cycle level.
- R6: level_o is the OR of the levels of all pending mapped sources, so several levels can be active at once.
- R7: While control bit 0 is 0, level_o is all zero and pending keeps tracking the inputs. Setting bit 0 again restores the levels of the sources still high.
- R8: raise_o bit k is high for exactly the one cycle in which level_o bit k goes from 0 to 1.
- R9: lower_o bit k is high for exactly the one cycle in which level_o bit k goes from 1 to 0.
- R10: A change on src_i, or a register write, shows on level_o at the second rising edge after the change (one pending stage, one level stage).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 8 | Level-sensitive interrupt request lines |
| reg_we_i | input | 1 | Control byte write strobe |
| reg_wdata_i | input | 8 | Control byte write data |
| reg_rdata_o | output | 8 | Stored control byte |
| level_o | output | 16 | Registered priority level vector |
| raise_o | output | 16 | One-cycle strobe per level going active |
| lower_o | output | 16 | One-cycle strobe per level going inactive |

## Verification
The assertions take src_i, reg_we_i and reg_wdata_i to be synchronous to clk_i and free of X once reset is released. They make no other assumption about them: any source pattern and any write sequence is legal. The bench drives every input at the falling edge, so each value is stable across the rising edge that samples it. Directed phases and a run of random source and write patterns both use only defined values.

// File: rtl/irq_map_pkg.sv
package irq_map_pkg;
  localparam int unsigned NUM_SRC = 8;
  localparam int unsigned NUM_LVL = 16;
  localparam int unsigned REG_W   = 8;

  localparam logic [REG_W-1:0] CTRL_RST   = 8'h01;
  localparam logic [REG_W-1:0] CTRL_WMASK = 8'hBF;
  localparam int unsigned      EN_BIT     = 0;

  // fixed source-to-level table; level 0 means "no level"
  function automatic int unsigned src_level(input int unsigned idx);
    case (idx)
      1:       return 1;
      2:       return 4;
      3:       return 6;
      4:       return 8;
      5:       return 10;
      7:       return 14;
      default: return 0;
    endcase
  endfunction

  function automatic logic [NUM_SRC-1:0] src_mask();
    logic [NUM_SRC-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_SRC; i++) m[i] = (src_level(i) != 0);
    return m;
  endfunction

  function automatic logic [NUM_LVL-1:0] lvl_mask();
    logic [NUM_LVL-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (src_level(i) != 0) m[src_level(i)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg #(
  parameter int unsigned      W     = 8,
  parameter logic [W-1:0]     RST_V = '0,
  parameter logic [W-1:0]     WMASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= RST_V;
    else if (we_i) q <= wdata_i & WMASK;
  end

  assign q_o = q;
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] pend_o
);
  import irq_map_pkg::*;

  localparam logic [NUM_SRC-1:0] MAPPED = NUM_SRC'(src_mask());

  logic unused_src;
  assign unused_src = ^(src_i & ~MAPPED);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    if (src_level(i) != 0) begin : g_flop
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= src_i[i];
      end
      assign pend_o[i] = q;
    end else begin : g_none
      assign pend_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_level_map.sv
module irq_level_map #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned NUM_LVL = 16
) (
  input  logic               en_i,
  input  logic [NUM_SRC-1:0] pend_i,
  output logic [NUM_LVL-1:0] lvl_o
);
  import irq_map_pkg::*;

  localparam logic [NUM_SRC-1:0] MAPPED = NUM_SRC'(src_mask());

  logic [NUM_LVL-1:0] contrib [NUM_SRC];
  logic [NUM_LVL-1:0] acc;
  logic               unused_pend;

  assign unused_pend = ^(pend_i & ~MAPPED);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int unsigned LV = src_level(i);
    if (LV != 0) begin : g_map
      localparam logic [NUM_LVL-1:0] ONEHOT = NUM_LVL'(1) << LV;
      assign contrib[i] = pend_i[i] ? ONEHOT : '0;
    end else begin : g_nomap
      assign contrib[i] = '0;
    end
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NUM_SRC; i++) acc = acc | contrib[i];
  end

  assign lvl_o = en_i ? acc : '0;
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] lvl_q, rise_q, fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      lvl_q  <= lvl_i;
      rise_q <= lvl_i & ~lvl_q;
      fall_q <= ~lvl_i & lvl_q;
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;
endmodule

// File: rtl/irq_level_mapper.sv
module irq_level_mapper
  import irq_map_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC,
  parameter int unsigned N_LVL = NUM_LVL,
  parameter int unsigned DW    = REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic             reg_we_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic [N_LVL-1:0] level_o,
  output logic [N_LVL-1:0] raise_o,
  output logic [N_LVL-1:0] lower_o
);
  logic [DW-1:0]    ctrl_q;
  logic [N_SRC-1:0] pend;
  logic [N_LVL-1:0] lvl_next;
  logic             unused_ctrl;

  irq_ctrl_reg #(
    .W    (DW),
    .RST_V(DW'(CTRL_RST)),
    .WMASK(DW'(CTRL_WMASK))
  ) i_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .wdata_i(reg_wdata_i),
    .q_o    (ctrl_q)
  );

  irq_pending #(.NUM_SRC(N_SRC)) i_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (src_i),
    .pend_o(pend)
  );

  irq_level_map #(.NUM_SRC(N_SRC), .NUM_LVL(N_LVL)) i_map (
    .en_i  (ctrl_q[EN_BIT]),
    .pend_i(pend),
    .lvl_o (lvl_next)
  );

  irq_edge_det #(.N(N_LVL)) i_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl_next),
    .lvl_o (level_o),
    .rise_o(raise_o),
    .fall_o(lower_o)
  );

  assign unused_ctrl = ^ctrl_q;
  assign reg_rdata_o = ctrl_q;
endmodule

// File: rtl/irq_level_mapper_chk.sv
module irq_level_mapper_chk
  import irq_map_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_SRC-1:0]   src_i,
  input logic                 reg_we_i,
  input logic [REG_W-1:0]     reg_wdata_i,
  input logic [REG_W-1:0]     reg_rdata_o,
  input logic [NUM_LVL-1:0]   level_o,
  input logic [NUM_LVL-1:0]   raise_o,
  input logic [NUM_LVL-1:0]   lower_o
);
  localparam logic [NUM_LVL-1:0] LMASK = lvl_mask();
  localparam logic [NUM_SRC-1:0] SMASK = src_mask();

  // R2
  wr_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> reg_rdata_o == ($past(reg_wdata_i) & 8'hBF));

  // R2
  bit6_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[6] == 1'b0);

  // R3
  lvl_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o & ~LMASK) == '0);

  // R5
  drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i & SMASK) == '0 |-> ##2 level_o == '0);

  // R7
  disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[0] |=> level_o == '0);

  // R8
  raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raise_o == (level_o & ~$past(level_o)));

  // R9
  lower_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lower_o == (~level_o & $past(level_o)));

  // R8
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raise_o & lower_o) == '0);
endmodule

bind irq_level_mapper irq_level_mapper_chk i_chk (.*);

// File: tb/test_irq_level_mapper.sv
module test_irq_level_mapper;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  src_i = '0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic [15:0] level_o, raise_o, lower_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_level_mapper i_irq_level_mapper (.*);

  typedef struct {
    logic [15:0] lvl, rise, fall;
    logic [7:0]  ctrl;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  // reference model state (state after the last modeled rising edge)
  logic [7:0]  m_pend = '0;
  logic [7:0]  m_ctrl = 8'h01;
  logic [15:0] m_lvl  = '0;

  function automatic int ref_level(int i);
    case (i)
      0: return 0;  1: return 1;  2: return 4;  3: return 6;
      4: return 8;  5: return 10; 6: return 0;  default: return 14;
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // drive one cycle and push what the outputs must be after the next rising edge
  task automatic step(logic [7:0] s, logic we, logic [7:0] wd, string tag);
    logic [15:0] nxt;
    exp_t e;
    @(negedge clk_i);
    src_i = s; reg_we_i = we; reg_wdata_i = wd;
    nxt = '0;
    if (m_ctrl[0])
      for (int i = 0; i < 8; i++)
        if (m_pend[i] && ref_level(i) != 0) nxt[ref_level(i)] = 1'b1;
    e.rise = nxt & ~m_lvl;
    e.fall = ~nxt & m_lvl;
    e.lvl  = nxt;
    m_lvl  = nxt;
    for (int i = 0; i < 8; i++) m_pend[i] = s[i] && ref_level(i) != 0;
    if (we) m_ctrl = wd & 8'hBF;
    e.ctrl = m_ctrl;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  // monitor
  always @(posedge clk_i) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(e.tag, "level_o", level_o, e.lvl);
      chk(e.tag, "raise_o", raise_o, e.rise);
      chk(e.tag, "lower_o", lower_o, e.fall);
      chk(e.tag, "reg_rdata_o", {8'h00, reg_rdata_o}, {8'h00, e.ctrl});
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state
    chk("R1", "reg_rdata_o", {8'h00, reg_rdata_o}, 16'h0001);
    chk("R1", "level_o", level_o, '0);
    chk("R1", "raise_o", raise_o, '0);
    chk("R1", "lower_o", lower_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R3 / R4: walk each source
    for (int i = 0; i < 8; i++) begin
      string t;
      t = (i == 0 || i == 6) ? "R4" : "R3";
      repeat (3) step(8'(1 << i), 1'b0, 8'h00, t);
      repeat (3) step(8'h00, 1'b0, 8'h00, t);
    end
    // R4: only unmapped sources held high
    repeat (4) step(8'h41, 1'b0, 8'h00, "R4");
    repeat (2) step(8'h00, 1'b0, 8'h00, "R4");

    // R5: one-cycle pulse, no latching
    step(8'h04, 1'b0, 8'h00, "R5");
    repeat (4) step(8'h00, 1'b0, 8'h00, "R5");

    // R10: explicit latency on bit 7 -> level 14
    step(8'h80, 1'b0, 8'h00, "R10");
    step(8'h80, 1'b0, 8'h00, "R10");
    @(posedge clk_i); #2;
    chk("R10", "level_o at second edge", level_o, 16'h4000);
    step(8'h00, 1'b0, 8'h00, "R10");
    repeat (3) step(8'h00, 1'b0, 8'h00, "R10");

    // R6: several levels together
    repeat (3) step(8'hBE, 1'b0, 8'h00, "R6");
    repeat (2) step(8'h22, 1'b0, 8'h00, "R6");
    repeat (3) step(8'h00, 1'b0, 8'h00, "R6");

    // R8 / R9: toggles on bit 3 -> level 6
    step(8'h08, 1'b0, 8'h00, "R8");
    repeat (2) step(8'h08, 1'b0, 8'h00, "R8");
    step(8'h00, 1'b0, 8'h00, "R9");
    repeat (2) step(8'h00, 1'b0, 8'h00, "R9");

    // R2: write path and bit 6 mask
    step(8'h00, 1'b1, 8'hFF, "R2");
    step(8'h00, 1'b1, 8'h41, "R2");
    step(8'h00, 1'b1, 8'hC3, "R2");
    step(8'h00, 1'b0, 8'h00, "R2");

    // R7: disable with sources high, then re-enable
    repeat (2) step(8'h30, 1'b0, 8'h00, "R7");
    step(8'h30, 1'b1, 8'h40, "R7");
    repeat (3) step(8'h32, 1'b0, 8'h00, "R7");
    step(8'h32, 1'b1, 8'h01, "R7");
    repeat (3) step(8'h32, 1'b0, 8'h00, "R7");
    repeat (3) step(8'h00, 1'b0, 8'h00, "R7");

    // R6: random mix of sources and writes
    for (int k = 0; k < 400; k++) begin
      logic we;
      we = ($urandom % 8) == 0;
      step(8'($urandom), we, 8'($urandom) | 8'h01 & 8'($urandom), "R6");
    end
    repeat (3) step(8'h00, 1'b0, 8'h00, "R6");

    @(negedge clk_i);
    @(negedge clk_i);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule